// File: doc/BRIEF.md
# Idle Mode Timer Controller

This block holds a small microcontroller core in a low-power wait. A free-running counter advances on every instruction-cycle clock. Software stops the core by writing a one to the idle bit of a three-bit control register. While stopped, the core-run enable output is low and only the counter and its controller keep working. The core is released by any change of counter bit 12 (every 4096 cycles), by an external wakeup request, or by reset.

Each change of bit 12 also latches a sticky pending flag. When software has set the enable bit, that flag drives the interrupt output. With the enable bit set, the core wakes and takes the timer interrupt first. With it clear, the core simply resumes at the next instruction.

The register port has no handshake. A write strobe carries a three-bit word, and the read word always shows the current state. Bit 0 is the idle bit, bit 1 is the interrupt enable and bit 2 is the pending flag.

Top module: `idle_tmr_ctrl`

## Requirements
- R1: While reset is low, and at the first sample after it is released, `reg_rdata` reads 3'b000, `irq` is 0 and `core_run` is 1. Reset clears the counter, the pending flag, the enable bit and the idle bit.
- R2: The counter is 0 at reset and increases by one on every clock edge after reset is released. Bit 12 therefore changes on edges 4096, 8192, 12288 and so on. The pending flag reads 1 from the edge after each of those, and not before.
- R3: A write with bit 0 set makes `core_run` low and `reg_rdata[0]` read 1 from the next edge. A write with bit 0 clear leaves `core_run` high.
- R4: A change of counter bit 12, rising or falling, ends idle one edge later, whatever the enable bit holds.
- R5: A one-cycle `wake_req` pulse ends idle on the next edge and leaves the pending flag unchanged. While running, `wake_req` has no effect.
- R6: The pending flag stays set until a write with bit 2 clear. A write with bit 2 set leaves the flag unchanged.
- R7: When a bit-12 change and a clearing write occur in the same cycle, the pending flag ends up set.
- R8: Bit 1 of each write is stored as the enable bit. `irq` is 1 exactly when both the pending flag and the enable bit are 1.
- R9: Asserting reset while idle forces `core_run` high at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | 3 | Write word: bit0 idle, bit1 enable, bit2 pending (0 clears) |
| wake_req | input | 1 | External wakeup request |
| reg_rdata | output | 3 | Read word: bit0 idle, bit1 enable, bit2 pending |
| irq | output | 1 | Timer interrupt request |
| core_run | output | 1 | High while the core may execute |

## Verification
The assertions check on every cycle that the counter steps by one, that idle entry follows an idle write, and that idle exit follows a toggle or a wakeup. They also check that the pending flag holds until it is cleared and that a set wins over a clear. Only the bench scenarios can show the exact 4096-cycle spacing of the toggle events, the falling-edge toggle caused by counter wrap, and the read-back encoding. The same holds for `wake_req` being ignored while running and for reset releasing idle asynchronously.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int unsigned REG_W  = 3;
  localparam int unsigned F_IDLE = 0;
  localparam int unsigned F_EN   = 1;
  localparam int unsigned F_PEND = 2;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_IDLE = 1'b1
  } mode_e;
endpackage

// File: rtl/itc_counter.sv
module itc_counter #(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned TAP   = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tog_o
);
  localparam int unsigned TAP_IDX = (TAP < CNT_W) ? TAP : CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             tap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tap_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tap_q <= cnt_q[TAP_IDX];
    end
  end

  assign tog_o = cnt_q[TAP_IDX] ^ tap_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/itc_pend.sv
module itc_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);
  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/itc_mode.sv
module itc_mode
  import itc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enter_i,
  input  logic  tog_i,
  input  logic  wake_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:  if (enter_i)         mode_d = MODE_IDLE;
      MODE_IDLE: if (tog_i || wake_i) mode_d = MODE_RUN;
      default:                        mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RUN;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R3
  enter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && enter_i) |=> mode_q == MODE_IDLE);
  // R4
  tog_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && tog_i) |=> mode_q == MODE_RUN);
  // R5
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && wake_i) |=> mode_q == MODE_RUN);
endmodule

// File: rtl/idle_tmr_ctrl.sv
module idle_tmr_ctrl
  import itc_pkg::*;
#(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned TAP   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             wake_req,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             core_run
);
  logic  tog;
  logic  pend;
  logic  en_q;
  mode_e mode;

  itc_counter #(.CNT_W(CNT_W), .TAP(TAP)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tog_o (tog)
  );

  itc_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (tog),
    .clr_i  (reg_we && !reg_wdata[F_PEND]),
    .pend_o (pend)
  );

  itc_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .enter_i (reg_we && reg_wdata[F_IDLE]),
    .tog_i   (tog),
    .wake_i  (wake_req),
    .mode_o  (mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (reg_we) en_q <= reg_wdata[F_EN];
  end

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[F_IDLE] = (mode == MODE_IDLE);
    reg_rdata[F_EN]   = en_q;
    reg_rdata[F_PEND] = pend;
  end

  assign irq      = pend && en_q;
  assign core_run = (mode == MODE_RUN);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (reg_rdata[F_PEND] && reg_rdata[F_EN]));
endmodule

// File: tb/idle_tmr_ctrl_tb.sv
module idle_tmr_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_wdata = 3'b000;
  logic       wake_req = 1'b0;
  logic [2:0] reg_rdata;
  logic       irq;
  logic       core_run;

  int vecs  = 0;
  int fails = 0;
  int edges = 0;
  bit done  = 1'b0;

  typedef struct {
    int         at;
    logic [4:0] obs;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  idle_tmr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .wake_req(wake_req), .reg_rdata(reg_rdata), .irq(irq), .core_run(core_run)
  );

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  task automatic compare(input logic [4:0] exp, input string req);
    logic [4:0] act;
    act = {core_run, irq, reg_rdata};
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at edge %0d: got run/irq/rd=%b expected %b", req, edges, act, exp);
    end
  endtask

  task automatic push_exp(input int at, input logic run, input logic ir,
                          input logic [2:0] rd, input string req);
    item_t it;
    it.at = at; it.obs = {run, ir, rd}; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wait_to(input int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic write_reg(input int n, input logic [2:0] w);
    wait_to(n);
    reg_we = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // monitor: pop and compare expectations as their edge arrives
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at == edges) begin
      compare(sb_q[0].obs, sb_q[0].req);
      void'(sb_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    // expectations, in edge order
    push_exp(3,     1'b0, 1'b0, 3'b001, "R3 idle entry");
    push_exp(4096,  1'b0, 1'b0, 3'b001, "R2 no pending before toggle");
    push_exp(4097,  1'b1, 1'b0, 3'b100, "R2 R4 rising toggle exits idle, enable clear");
    push_exp(4200,  1'b1, 1'b0, 3'b100, "R6 pending holds");
    push_exp(4201,  1'b1, 1'b1, 3'b110, "R8 irq with enable, R6 write of 1 keeps flag");
    push_exp(4301,  1'b1, 1'b0, 3'b010, "R6 clear, R3 idle bit 0 keeps running");
    push_exp(4401,  1'b0, 1'b0, 3'b011, "R3 idle entry with enable");
    push_exp(4501,  1'b1, 1'b0, 3'b010, "R5 wake ends idle, no pending");
    push_exp(4551,  1'b1, 1'b0, 3'b010, "R5 wake ignored while running");
    push_exp(4601,  1'b0, 1'b0, 3'b011, "R3 idle entry again");
    push_exp(8192,  1'b0, 1'b0, 3'b011, "R2 still idle before falling toggle");
    push_exp(8193,  1'b1, 1'b1, 3'b110, "R4 R8 falling toggle exits and interrupts");
    push_exp(12289, 1'b1, 1'b1, 3'b110, "R7 set wins over clear");
    push_exp(12301, 1'b1, 1'b0, 3'b010, "R6 later clear");
    push_exp(12401, 1'b0, 1'b0, 3'b011, "R3 idle before reset");

    #1;
    compare(5'b10000, "R1 state during reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare(5'b10000, "R1 state after release");

    write_reg(2, 3'b001);
    write_reg(4200, 3'b110);
    write_reg(4300, 3'b010);
    write_reg(4400, 3'b011);
    wait_to(4500);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    wait_to(4550);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    write_reg(4600, 3'b011);
    write_reg(12288, 3'b010);
    write_reg(12300, 3'b010);
    write_reg(12400, 3'b011);
    wait_to(12450);
    rst_n = 1'b0;
    #1;
    compare(5'b10000, "R9 reset releases idle at once");
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule